// File: doc/BRIEF.md
# Asynchronous Strobe-Driven Register Bus Slave

This block lets a host processor reach a small bank of 8-bit registers over an asynchronous programmed-I/O bus. The bus has separate active-low read and write strobes, an active-low chip select, and an address latch enable. The host places an address on the bus and qualifies it with the latch enable. It then pulses a strobe and waits for the block to pull its active-low ready output low. The bidirectional data bus is split into an input, an output and an output enable, which a pad wrapper joins into one tri-state bus.

All strobes are brought into the local clock through two-flop synchronizers. The address and write data pass through matching delay stages, so they stay aligned with the strobes. The address is held by a latch. The latch follows the bus while the enable is high and freezes when the enable drops. Tying the enable high therefore gives a transparent address path. A small state machine turns each strobe pulse into exactly one register access and one ready acknowledge. It drops the acknowledge once both strobes are back high.

Top module: `ibs_bus_slave`

## Requirements
- R1: While `rst` is high and after it falls, every register reads as 0x00, `data_oe_o` is 0 and `rdy_n_o` is 1.
- R2: With `cs_n_i` low and `rd_n_i` high, a falling `wr_n_i` stores `data_i` into the register at the latched address. `rdy_n_o` then goes low within 6 clocks, and each WR pulse produces exactly one store.
- R3: With `cs_n_i` low and `wr_n_i` high, a falling `rd_n_i` raises `data_oe_o` and drives `rdy_n_o` low within 6 clocks, and `data_o` then carries the addressed register's content.
- R4: Once `rd_n_i` and `wr_n_i` are both high again, `rdy_n_o` returns to 1 and `data_oe_o` to 0 within 6 clocks.
- R5: The address is taken from `addr_i` while `ale_i` is high and held after `ale_i` falls. Changes on `addr_i` while `ale_i` is low do not change the accessed register.
- R6: With `ale_i` held high permanently, each access uses the current value of `addr_i`.
- R7: While `cs_n_i` is high, strobes are ignored: nothing is stored, `rdy_n_o` stays 1 and `data_oe_o` stays 0.
- R8: If `rd_n_i` and `wr_n_i` are low together, the access is ignored: nothing is stored, `rdy_n_o` stays 1 and `data_oe_o` stays 0.
- R9: `data_oe_o` is never 1 on the clock after synchronized WR is seen low. A read that is interrupted by WR going low releases the bus within 6 clocks.
- R10: Only addresses below NUM_REGS (default 16) hold registers. A read of a higher address returns 0x00, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 8 | Host address bus |
| ale_i | input | 1 | Address latch enable, high = follow bus |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| data_i | input | 8 | Data bus, host to block |
| data_o | output | 8 | Data bus, block to host |
| data_oe_o | output | 1 | Output enable for the data bus |
| rdy_n_o | output | 1 | Ready acknowledge, active low |

## Verification
Writes and reads run under three address patterns: ALE pulsed, ALE pulsed and the bus then changed, and ALE tied high. These show whether the latch freezes the address or follows it. Further strobe patterns cover chip select high, both strobes low, and a write strobe arriving in the middle of a read. Each of these is followed by a read-back, which shows whether an ignored strobe altered a register. Accesses above the bank size check address decoding against the aliasing of the low address bits, and a late reset shows that the registers are cleared.

// File: rtl/ibs_pkg.sv
package ibs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WACK = 2'd2
  } bus_state_e;
endpackage

// File: rtl/ibs_sync.sv
module ibs_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ibs_addr_latch.sv
module ibs_addr_latch #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale_s,
  input  logic [AW-1:0] addr_s,
  output logic [AW-1:0] addr_q
);
  // follows the bus while enable is high, holds once it drops
  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (ale_s) addr_q <= addr_s;
  end
endmodule

// File: rtl/ibs_regbank.sv
module ibs_regbank #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NUM_REGS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DW-1:0] mem [NUM_REGS];
  logic          in_range;

  assign in_range = ({1'b0, addr} < (AW+1)'(NUM_REGS));

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) mem[g] <= '0;
        else if (we && addr == AW'(g)) mem[g] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (in_range) rdata <= mem[addr[IDX_W-1:0]];
    else rdata <= '0;
  end
endmodule

// File: rtl/ibs_ctrl.sv
module ibs_ctrl
  import ibs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic rd_s,
  input  logic wr_s,
  output logic we,
  output logic oe,
  output logic rdy_n
);
  bus_state_e st;

  logic rd_req, wr_req;
  assign rd_req = !cs_s && !rd_s && wr_s;
  assign wr_req = !cs_s && !wr_s && rd_s;
  // single commit: only the idle state can launch a store
  assign we = (st == ST_IDLE) && wr_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      oe    <= 1'b0;
      rdy_n <= 1'b1;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (rd_req) begin
            st    <= ST_READ;
            oe    <= 1'b1;
            rdy_n <= 1'b0;
          end else if (wr_req) begin
            st    <= ST_WACK;
            rdy_n <= 1'b0;
          end
        end
        ST_READ: begin
          if (rd_s || cs_s || !wr_s) begin
            st    <= ST_IDLE;
            oe    <= 1'b0;
            rdy_n <= 1'b1;
          end
        end
        ST_WACK: begin
          if (rd_s && wr_s) begin
            st    <= ST_IDLE;
            rdy_n <= 1'b1;
          end
        end
        default: begin
          st    <= ST_IDLE;
          oe    <= 1'b0;
          rdy_n <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/ibs_bus_slave.sv
module ibs_bus_slave #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NUM_REGS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          ale_i,
  input  logic          cs_n_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          rdy_n_o
);
  localparam int CW = 4;
  localparam int PW = AW + DW;

  logic [CW-1:0] ctl_s;
  logic [PW-1:0] pay_s;
  logic          ale_s, cs_s, rd_s, wr_s;
  logic [AW-1:0] addr_s, addr_q;
  logic [DW-1:0] din_s;
  logic          we;

  ibs_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) u_ctl_sync (
    .clk(clk), .rst(rst),
    .d({ale_i, cs_n_i, rd_n_i, wr_n_i}),
    .q(ctl_s)
  );

  // payload delayed by the same depth so it lines up with the strobes
  ibs_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pay_sync (
    .clk(clk), .rst(rst),
    .d({addr_i, data_i}),
    .q(pay_s)
  );

  assign {ale_s, cs_s, rd_s, wr_s} = ctl_s;
  assign {addr_s, din_s} = pay_s;

  ibs_addr_latch #(.AW(AW)) u_alat (
    .clk(clk), .rst(rst),
    .ale_s(ale_s), .addr_s(addr_s), .addr_q(addr_q)
  );

  ibs_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .cs_s(cs_s), .rd_s(rd_s), .wr_s(wr_s),
    .we(we), .oe(data_oe_o), .rdy_n(rdy_n_o)
  );

  ibs_regbank #(.AW(AW), .DW(DW), .NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst(rst),
    .we(we), .addr(addr_q), .wdata(din_s), .rdata(data_o)
  );
endmodule

// File: rtl/ibs_bus_chk.sv
module ibs_bus_chk (
  input logic clk,
  input logic rst,
  input logic rd_s,
  input logic wr_s,
  input logic we,
  input logic data_oe_o,
  input logic rdy_n_o
);
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (rdy_n_o && !data_oe_o));

  p_store_acked_r2: assert property (@(posedge clk) disable iff (rst) we |=> !rdy_n_o);

  p_single_store_r2: assert property (@(posedge clk) disable iff (rst) we |=> !we);

  p_oe_has_ack_r3: assert property (@(posedge clk) disable iff (rst) data_oe_o |-> !rdy_n_o);

  p_release_r4: assert property (@(posedge clk) disable iff (rst) (rd_s && wr_s) |=> rdy_n_o);

  p_both_low_r8: assert property (@(posedge clk) disable iff (rst)
    (!rd_s && !wr_s && rdy_n_o) |=> (rdy_n_o && !we));

  p_no_oe_on_wr_r9: assert property (@(posedge clk) disable iff (rst) !wr_s |=> !data_oe_o);
endmodule

bind ibs_bus_slave ibs_bus_chk u_chk (
  .clk(clk), .rst(rst), .rd_s(rd_s), .wr_s(wr_s), .we(we),
  .data_oe_o(data_oe_o), .rdy_n_o(rdy_n_o)
);

// File: tb/ibs_bus_slave_tb.sv
module ibs_bus_slave_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr_i = 8'h00;
  logic       ale_i = 1'b0;
  logic       cs_n_i = 1'b1;
  logic       rd_n_i = 1'b1;
  logic       wr_n_i = 1'b1;
  logic [7:0] data_i = 8'h00;
  logic [7:0] data_o;
  logic       data_oe_o;
  logic       rdy_n_o;

  int total = 0;
  int bad = 0;
  logic [7:0] model [16];
  logic [7:0] exp_q [$];
  string      cur_req = "R3";
  bit         seen = 0;

  always #4 clk = ~clk;

  ibs_bus_slave u_dut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .ale_i(ale_i),
    .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o), .rdy_n_o(rdy_n_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares the first cycle of each read acknowledge
  always @(negedge clk) begin
    if (!rst && !rdy_n_o && data_oe_o && !seen) begin
      seen = 1;
      if (exp_q.size() == 0) check(0, cur_req, data_o, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        check(data_o == e, cur_req, data_o, e);
      end
    end else if (rdy_n_o) seen = 0;
  end

  task automatic wait_rdy(input logic v, output bit ok);
    ok = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (rdy_n_o === v) begin ok = 1; break; end
    end
  endtask

  // mode 0: pulse ALE, mode 1: ALE held high, mode 2: no address phase
  task automatic addr_phase(input int a, input int mode);
    if (mode == 2) return;
    @(negedge clk);
    addr_i = 8'(a);
    ale_i = 1'b1;
    repeat (3) @(negedge clk);
    if (mode == 0) begin
      ale_i = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic bus_write(input int a, input logic [7:0] d, input int mode, input string req);
    bit ok;
    addr_phase(a, mode);
    cs_n_i = 1'b0;
    data_i = d;
    @(negedge clk);
    wr_n_i = 1'b0;
    wait_rdy(1'b0, ok);
    check(ok, {req, "/R2 write ack"}, rdy_n_o, 0);
    wr_n_i = 1'b1;
    wait_rdy(1'b1, ok);
    check(ok && !data_oe_o, "R4 write release", rdy_n_o, 1);
    cs_n_i = 1'b1;
    if (a < 16) model[a] = d;
  endtask

  task automatic bus_read(input int a, input int mode, input string req);
    bit ok;
    addr_phase(a, mode);
    cur_req = req;
    exp_q.push_back((a < 16) ? model[a] : 8'h00);
    cs_n_i = 1'b0;
    @(negedge clk);
    rd_n_i = 1'b0;
    wait_rdy(1'b0, ok);
    check(ok, {req, "/R3 read ack"}, rdy_n_o, 0);
    repeat (2) @(negedge clk);
    rd_n_i = 1'b1;
    wait_rdy(1'b1, ok);
    check(ok && !data_oe_o, "R4 read release", {data_oe_o, rdy_n_o}, 1);
    cs_n_i = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit quiet;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    check(rdy_n_o && !data_oe_o, "R1 reset outputs", {data_oe_o, rdy_n_o}, 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(rdy_n_o && !data_oe_o, "R1 idle after reset", {data_oe_o, rdy_n_o}, 1);
    bus_read(0, 0, "R1");
    bus_read(15, 0, "R1");

    // R2/R3: several patterns
    bus_write(1, 8'hA5, 0, "R2");
    bus_write(2, 8'h5A, 0, "R2");
    bus_write(15, 8'hFF, 0, "R2");
    bus_read(1, 0, "R3");
    bus_read(2, 0, "R3");
    bus_read(15, 0, "R3");
    bus_write(1, 8'h3C, 0, "R2");
    bus_read(1, 0, "R2");

    // R5: bus changes after ALE falls
    addr_phase(3, 0);
    addr_i = 8'h09;
    bus_write(3, 8'h77, 2, "R5");
    addr_phase(9, 0);
    addr_i = 8'h03;
    bus_read(9, 2, "R5");
    bus_read(3, 0, "R5");

    // R6: ALE held high
    bus_write(7, 8'h81, 1, "R6");
    bus_write(8, 8'h18, 1, "R6");
    bus_read(7, 1, "R6");
    bus_read(8, 1, "R6");
    ale_i = 1'b0;

    // R7: chip select high
    addr_phase(4, 0);
    data_i = 8'hEE;
    quiet = 1;
    wr_n_i = 1'b0;
    repeat (8) begin @(negedge clk); if (!rdy_n_o || data_oe_o) quiet = 0; end
    wr_n_i = 1'b1;
    rd_n_i = 1'b0;
    repeat (8) begin @(negedge clk); if (!rdy_n_o || data_oe_o) quiet = 0; end
    rd_n_i = 1'b1;
    repeat (4) @(negedge clk);
    check(quiet, "R7 no response without cs", quiet, 1);
    bus_read(4, 2, "R7");

    // R8: both strobes low together
    addr_phase(5, 0);
    data_i = 8'hDD;
    cs_n_i = 1'b0;
    @(negedge clk);
    quiet = 1;
    rd_n_i = 1'b0;
    wr_n_i = 1'b0;
    repeat (10) begin @(negedge clk); if (!rdy_n_o || data_oe_o) quiet = 0; end
    cs_n_i = 1'b1;
    repeat (4) @(negedge clk);
    rd_n_i = 1'b1;
    wr_n_i = 1'b1;
    repeat (4) @(negedge clk);
    check(quiet, "R8 both low ignored", quiet, 1);
    bus_read(5, 2, "R8");

    // R9: write strobe during a read
    begin
      bit ok;
      addr_phase(2, 0);
      cur_req = "R9";
      exp_q.push_back(model[2]);
      cs_n_i = 1'b0;
      @(negedge clk);
      rd_n_i = 1'b0;
      wait_rdy(1'b0, ok);
      check(ok && data_oe_o, "R9 read started", data_oe_o, 1);
      wr_n_i = 1'b0;
      ok = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (!data_oe_o && rdy_n_o) begin ok = 1; break; end
      end
      check(ok, "R9 bus released on WR", data_oe_o, 0);
      cs_n_i = 1'b1;
      repeat (4) @(negedge clk);
      rd_n_i = 1'b1;
      wr_n_i = 1'b1;
      repeat (4) @(negedge clk);
    end
    bus_read(2, 0, "R9");

    // R10: above the bank
    bus_write(8'h25, 8'h99, 0, "R10");
    bus_read(8'h25, 0, "R10");
    bus_read(5, 0, "R10");
    bus_read(8'hF0, 0, "R10");

    // R1: late reset clears registers
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    bus_read(1, 0, "R1");
    bus_read(7, 0, "R1");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule